// File: doc/BRIEF.md
# Microwire Serial EEPROM Command Master

This block drives a small three-wire serial EEPROM at the bit level. The host places an opcode, an address and, where needed, a data word on its command inputs and pulses `start`. The block then raises the chip select and clocks out a command frame. It then does one of three things. For a read, it discards the device's leading zero and collects a 16-bit word. For a write or a fill, it appends a 16-bit data word. For program and erase commands, it checks the device's ready line until the device answers or a retry limit runs out.

All serial timing is built from one time slot of `HALF_PERIOD_CLKS` system clocks. Each bit costs three slots: data setup, clock high and clock low. The select line has a one-slot setup after it rises and a one-slot low time before the block reports completion. `busy` covers the whole operation. `done` is a single-cycle pulse at the end. `timeout` reports a failed ready check and holds until the next command starts.

Top module: `mw_eeprom_master`

## Requirements
- R1: While reset is held and while idle, `ser_sel`, `ser_clk` and `ser_out` are low; after reset `busy`, `done`, `timeout` are low and `rdata` is zero.
- R2: Each command frame begins with ten bits sent MSB first: a 1, then the two-bit opcode, then the seven address bits A6..A0. `ser_out` is set up one slot before each `ser_clk` rise and holds while `ser_clk` is high.
- R3: The opcode encodings are 10 read, 01 write, 11 erase, and 00 extended. For extended commands, address bits 6:5 choose the sub-operation: 00 write-protect, 01 fill-all, 10 erase-all, 11 write-unlock. Write and fill-all append the 16 bits of `cmd_wdata` MSB first, giving 26 clock pulses.
- R4: A read spends one clock pulse on the device's leading zero. It then captures 16 bits from `ser_in` MSB first, for 27 pulses in total. `rdata` changes only at the end of a read and keeps its value across other commands.
- R5: The slot is `HALF_PERIOD_CLKS` clocks. A command runs 1 setup slot, 3 slots per bit, any poll slots, and 1 final low slot. For example, with a ready device a read and a write both take 83 slots, write-unlock takes 32 and erase takes 35.
- R6: Write, erase, fill-all and erase-all are followed by a ready check. The select line drops for one slot, rises for one setup slot, and then `ser_in` is sampled at the end of each slot. A high level ends the command successfully.
- R7: If ten samples in a row read low, the command ends with `timeout` high. `timeout` rises together with `done` and stays high until the next `start` is accepted.
- R8: Write-unlock and write-protect use a single select session of 10 pulses with no ready check.
- R9: `busy` rises in the cycle after `start` is accepted and stays high until completion. `done` is a one-cycle pulse in the cycle `busy` falls.
- R10: A `start` pulse while `busy` is high is ignored and does not change the running frame or its duration.
- R11: `ser_clk` idles low and is high only while `ser_sel` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request pulse, taken when idle |
| cmd_op | input | 2 | Command opcode |
| cmd_addr | input | ADDR_W | Word address or extended sub-operation |
| cmd_wdata | input | DATA_W | Data word for write and fill-all |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ready check gave up (held until next start) |
| rdata | output | DATA_W | Last word read |
| ser_sel | output | 1 | Device select, active high |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Serial data to the device |
| ser_in | input | 1 | Serial data and ready from the device |

## Verification
Most internal faults in this block show up at the pins as a change in length. If the bit counter or the phase register slips, the pulse count inside the select session changes. The total `busy` length then moves by a multiple of three slots, and that is visible when `done` arrives. If the dummy-bit handling or the capture shift is wrong, `rdata` comes out rotated by one place or with a bit lost. A fault in the poll counter or its exit test changes how often `ser_sel` rises. It also moves the command's end by whole slots, or reports `timeout` on a device that was ready, all within one command.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CSS,
    ST_BSET,
    ST_BHI,
    ST_BLO,
    ST_GAP,
    ST_PSET,
    ST_PSAMP,
    ST_END
  } mw_state_e;

  typedef enum logic [1:0] {
    PH_TX,
    PH_DUMMY,
    PH_RX
  } mw_phase_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef struct packed {
    logic has_wdata;
    logic is_read;
    logic needs_poll;
  } mw_plan_t;

endpackage

// File: rtl/mw_rst_sync.sv
module mw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int PERIOD = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
  import mw_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output mw_plan_t          plan
);
  logic [1:0] sub;
  assign sub = addr[ADDR_W-1 -: 2];

  always_comb begin
    plan = '0;
    unique case (op)
      OPC_READ:  plan.is_read = 1'b1;
      OPC_WRITE: begin
        plan.has_wdata  = 1'b1;
        plan.needs_poll = 1'b1;
      end
      OPC_ERASE: plan.needs_poll = 1'b1;
      default: begin
        unique case (sub)
          SUB_FILL: begin
            plan.has_wdata  = 1'b1;
            plan.needs_poll = 1'b1;
          end
          SUB_WIPE: plan.needs_poll = 1'b1;
          default:  plan = '0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mw_seq.sv
module mw_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int POLLS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  mw_plan_t          plan,
  input  logic              ser_in,
  output logic              run,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] rdata,
  output logic              ser_sel,
  output logic              ser_clk,
  output logic              ser_out
);
  localparam int HDR_W = 3 + ADDR_W;
  localparam int TX_W  = HDR_W + DATA_W;
  localparam int BCW   = $clog2(TX_W);
  localparam int PCW   = (POLLS > 1) ? $clog2(POLLS) : 1;
  localparam logic [BCW-1:0] TX_LAST_LONG  = BCW'(TX_W - 1);
  localparam logic [BCW-1:0] TX_LAST_SHORT = BCW'(HDR_W - 1);
  localparam logic [BCW-1:0] RX_LAST       = BCW'(DATA_W - 1);
  localparam logic [PCW-1:0] POLL_LAST     = PCW'(POLLS - 1);

  mw_state_e         state_q, state_d;
  mw_phase_e         phase_q, phase_d;
  logic [BCW-1:0]    bitcnt_q, bitcnt_d;
  logic [TX_W-1:0]   txsh_q, txsh_d;
  logic [DATA_W-1:0] rxsh_q, rxsh_d;
  mw_plan_t          plan_q, plan_d;
  logic [PCW-1:0]    pollcnt_q, pollcnt_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              tmo_q, tmo_d;
  logic              done_q, done_d;
  logic              sel_q, sel_d;
  logic              clk_q, clk_d;
  logic              out_q, out_d;
  logic [BCW-1:0]    tx_last;

  assign tx_last = plan_q.has_wdata ? TX_LAST_LONG : TX_LAST_SHORT;

  // next-state process
  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    bitcnt_d  = bitcnt_q;
    txsh_d    = txsh_q;
    rxsh_d    = rxsh_q;
    plan_d    = plan_q;
    pollcnt_d = pollcnt_q;
    rdata_d   = rdata_q;
    tmo_d     = tmo_q;
    done_d    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_CSS;
          phase_d   = PH_TX;
          bitcnt_d  = '0;
          pollcnt_d = '0;
          plan_d    = plan;
          txsh_d    = {1'b1, op, addr, wdata};
          tmo_d     = 1'b0;
        end
      end
      ST_CSS:  if (tick) state_d = ST_BSET;
      ST_BSET: if (tick) state_d = ST_BHI;
      ST_BHI: begin
        if (tick) begin
          state_d = ST_BLO;
          if (phase_q == PH_RX) rxsh_d = {rxsh_q[DATA_W-2:0], ser_in};
        end
      end
      ST_BLO: begin
        if (tick) begin
          unique case (phase_q)
            PH_TX: begin
              txsh_d = {txsh_q[TX_W-2:0], 1'b0};
              if (bitcnt_q == tx_last) begin
                bitcnt_d = '0;
                if (plan_q.is_read) begin
                  phase_d = PH_DUMMY;
                  state_d = ST_BSET;
                end else if (plan_q.needs_poll) begin
                  state_d = ST_GAP;
                end else begin
                  state_d = ST_END;
                end
              end else begin
                bitcnt_d = bitcnt_q + 1'b1;
                state_d  = ST_BSET;
              end
            end
            PH_DUMMY: begin
              phase_d  = PH_RX;
              bitcnt_d = '0;
              state_d  = ST_BSET;
            end
            default: begin
              if (bitcnt_q == RX_LAST) begin
                rdata_d = rxsh_q;
                state_d = ST_END;
              end else begin
                bitcnt_d = bitcnt_q + 1'b1;
                state_d  = ST_BSET;
              end
            end
          endcase
        end
      end
      ST_GAP:  if (tick) state_d = ST_PSET;
      ST_PSET: if (tick) state_d = ST_PSAMP;
      ST_PSAMP: begin
        if (tick) begin
          if (ser_in) begin
            state_d = ST_END;
          end else if (pollcnt_q == POLL_LAST) begin
            tmo_d   = 1'b1;
            state_d = ST_END;
          end else begin
            pollcnt_d = pollcnt_q + 1'b1;
          end
        end
      end
      ST_END: begin
        if (tick) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    sel_d = state_d inside {ST_CSS, ST_BSET, ST_BHI, ST_BLO, ST_PSET, ST_PSAMP};
    clk_d = (state_d == ST_BHI);
    out_d = (state_d inside {ST_BSET, ST_BHI, ST_BLO}) && (phase_d == PH_TX)
            && txsh_d[TX_W-1];
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_TX;
      bitcnt_q  <= '0;
      txsh_q    <= '0;
      rxsh_q    <= '0;
      plan_q    <= '0;
      pollcnt_q <= '0;
      rdata_q   <= '0;
      tmo_q     <= 1'b0;
      done_q    <= 1'b0;
      sel_q     <= 1'b0;
      clk_q     <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      bitcnt_q  <= bitcnt_d;
      txsh_q    <= txsh_d;
      rxsh_q    <= rxsh_d;
      plan_q    <= plan_d;
      pollcnt_q <= pollcnt_d;
      rdata_q   <= rdata_d;
      tmo_q     <= tmo_d;
      done_q    <= done_d;
      sel_q     <= sel_d;
      clk_q     <= clk_d;
      out_q     <= out_d;
    end
  end

  assign run     = (state_q != ST_IDLE);
  assign done    = done_q;
  assign timeout = tmo_q && (state_q == ST_IDLE);
  assign rdata   = rdata_q;
  assign ser_sel = sel_q;
  assign ser_clk = clk_q;
  assign ser_out = out_q;
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int HALF_PERIOD_CLKS = 25,
  parameter int ADDR_W           = 7,
  parameter int DATA_W           = 16,
  parameter int POLL_LIMIT       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] rdata,
  output logic              ser_sel,
  output logic              ser_clk,
  output logic              ser_out,
  input  logic              ser_in
);
  logic     rst_core_n;
  logic     tick;
  logic     run;
  mw_plan_t plan;

  mw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mw_tick_gen #(.PERIOD(HALF_PERIOD_CLKS)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (run),
    .tick  (tick)
  );

  mw_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .op   (cmd_op),
    .addr (cmd_addr),
    .plan (plan)
  );

  mw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLLS(POLL_LIMIT)) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick),
    .start   (start),
    .op      (cmd_op),
    .addr    (cmd_addr),
    .wdata   (cmd_wdata),
    .plan    (plan),
    .ser_in  (ser_in),
    .run     (run),
    .done    (done),
    .timeout (timeout),
    .rdata   (rdata),
    .ser_sel (ser_sel),
    .ser_clk (ser_clk),
    .ser_out (ser_out)
  );

  assign busy = run;
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic [DATA_W-1:0] rdata,
  input logic              ser_sel,
  input logic              ser_clk,
  input logic              ser_out
);
  a_r11_clk_inside_sel: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> ser_sel);

  a_r1_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_sel && !ser_clk && !ser_out));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_out));

  a_r4_rdata_moves_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> busy);

  a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

bind mw_eeprom_master mw_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .timeout (timeout),
  .rdata   (rdata),
  .ser_sel (ser_sel),
  .ser_clk (ser_clk),
  .ser_out (ser_out)
);

// File: tb/tb_mw_eeprom_master.sv
`timescale 1ns/1ps
module tb_mw_eeprom_master;
  localparam int HP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [6:0]  cmd_addr = 7'h00;
  logic [15:0] cmd_wdata = 16'h0000;
  logic        busy, done, timeout;
  logic [15:0] rdata;
  logic        ser_sel, ser_clk, ser_out, ser_in;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mw_eeprom_master #(.HALF_PERIOD_CLKS(HP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .timeout(timeout), .rdata(rdata), .ser_sel(ser_sel), .ser_clk(ser_clk),
    .ser_out(ser_out), .ser_in(ser_in)
  );

  // ---------------- device model ----------------
  logic [15:0] rd_mem = 16'h0000;
  logic        ready_lvl = 1'b1;
  logic [31:0] cap = '0;
  logic [31:0] last_cap = '0;
  int          sess_cnt = 0;
  int          last_bits = 0;
  int          sess_n = 0;
  logic        rd_mode = 1'b0;
  logic        so_q = 1'b0;
  int          rd_idx = 0;

  always @(posedge ser_clk or negedge ser_sel) begin
    if (!ser_sel) begin
      if (sess_cnt != 0) begin
        last_bits = sess_cnt;
        last_cap  = cap;
      end
      sess_cnt = 0;
      cap      = '0;
    end else begin
      cap = {cap[30:0], ser_out};
      sess_cnt++;
    end
  end

  always @(posedge ser_sel) sess_n++;

  always @(negedge ser_clk or negedge ser_sel) begin
    if (!ser_sel) begin
      rd_mode = 1'b0;
      rd_idx  = 0;
      so_q    = 1'b0;
    end else if (!rd_mode && sess_cnt == 10 && cap[8:7] == 2'b10) begin
      rd_mode = 1'b1;
      so_q    = 1'b0;
      rd_idx  = 1;
    end else if (rd_mode && rd_idx <= 16) begin
      so_q = rd_mem[16 - rd_idx];
      rd_idx++;
    end
  end

  assign ser_in = rd_mode ? so_q : ready_lvl;

  // ---------------- checking ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [6:0] addr,
                         input logic [15:0] wd, input int poke,
                         output int cyc, output int sessions);
    int s0;
    s0 = sess_n;
    @(negedge clk);
    cmd_op = op; cmd_addr = addr; cmd_wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 timeout clear while busy", {31'd0, timeout}, 32'd0);
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
      if (poke != 0 && cyc == poke) begin
        cmd_op = 2'b10; cmd_addr = 7'h11; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check("R9 done at busy fall", {31'd0, done}, 32'd1);
    sessions = sess_n - s0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  addr;
    logic [15:0] wd;
    logic [15:0] mem;
    logic        rdy;
    logic [5:0]  bits;
    logic [1:0]  sess;
    logic        tmo;
    logic [7:0]  per;
    logic [15:0] rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 7'h25, 16'h0000, 16'hA55A, 1'b1, 6'd27, 2'd1, 1'b0, 8'd83, 16'hA55A}, // R4 read
    '{2'b10, 7'h7F, 16'h0000, 16'h8001, 1'b1, 6'd27, 2'd1, 1'b0, 8'd83, 16'h8001}, // R4 read
    '{2'b01, 7'h13, 16'h3C96, 16'h0000, 1'b1, 6'd26, 2'd2, 1'b0, 8'd83, 16'h8001}, // R3 write
    '{2'b11, 7'h40, 16'h0000, 16'h0000, 1'b1, 6'd10, 2'd2, 1'b0, 8'd35, 16'h8001}, // R6 erase
    '{2'b00, 7'h60, 16'hFFFF, 16'h0000, 1'b1, 6'd10, 2'd1, 1'b0, 8'd32, 16'h8001}, // R8 unlock
    '{2'b00, 7'h00, 16'hFFFF, 16'h0000, 1'b1, 6'd10, 2'd1, 1'b0, 8'd32, 16'h8001}, // R8 protect
    '{2'b00, 7'h20, 16'hF00F, 16'h0000, 1'b1, 6'd26, 2'd2, 1'b0, 8'd83, 16'h8001}, // R3 fill-all
    '{2'b00, 7'h40, 16'h0000, 16'h0000, 1'b1, 6'd10, 2'd2, 1'b0, 8'd35, 16'h8001}, // R6 erase-all
    '{2'b01, 7'h01, 16'h1234, 16'h0000, 1'b0, 6'd26, 2'd2, 1'b1, 8'd92, 16'h8001}, // R7 timeout
    '{2'b11, 7'h05, 16'h0000, 16'h0000, 1'b0, 6'd10, 2'd2, 1'b1, 8'd44, 16'h8001}  // R7 timeout
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int cyc, sessions;
    logic [31:0] hdr;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 sel in reset", {31'd0, ser_sel}, 32'd0);
    check("R11 clk in reset", {31'd0, ser_clk}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy idle", {31'd0, busy}, 32'd0);
    check("R1 done idle", {31'd0, done}, 32'd0);
    check("R1 timeout idle", {31'd0, timeout}, 32'd0);
    check("R1 rdata idle", {16'd0, rdata}, 32'd0);
    check("R1 out idle", {31'd0, ser_out}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      rd_mem    = VECS[i].mem;
      ready_lvl = VECS[i].rdy;
      run_cmd(VECS[i].op, VECS[i].addr, VECS[i].wd, 0, cyc, sessions);
      hdr = (last_cap >> (last_bits - 10)) & 32'h3FF;
      check("R2 header", hdr, {22'd0, 1'b1, VECS[i].op, VECS[i].addr});
      check("R3 pulse count", last_bits, {26'd0, VECS[i].bits});
      if (VECS[i].bits == 6'd26)
        check("R3 data bits", {16'd0, last_cap[15:0]}, {16'd0, VECS[i].wd});
      check("R6/R8 sessions", sessions, {30'd0, VECS[i].sess});
      check("R7 timeout", {31'd0, timeout}, {31'd0, VECS[i].tmo});
      check("R5 busy length", cyc, VECS[i].per * HP);
      check("R4 rdata", {16'd0, rdata}, {16'd0, VECS[i].rd});
      if (VECS[i].tmo) begin
        repeat (5) @(negedge clk);
        check("R7 timeout held", {31'd0, timeout}, 32'd1);
      end
    end

    // R6 device becomes ready on the fourth sample
    ready_lvl = 1'b0;
    fork
      begin
        int s0;
        s0 = sess_n;
        wait (sess_n == s0 + 2);
        repeat (4 * HP) @(posedge clk);
        @(negedge clk);
        ready_lvl = 1'b1;
      end
    join_none
    run_cmd(2'b11, 7'h05, 16'h0000, 0, cyc, sessions);
    check("R6 late ready length", cyc, 38 * HP);
    check("R6 late ready no timeout", {31'd0, timeout}, 32'd0);

    // R10 start during busy is ignored
    ready_lvl = 1'b1;
    run_cmd(2'b00, 7'h60, 16'h0000, 20, cyc, sessions);
    check("R10 length unchanged", cyc, 32 * HP);
    check("R10 pulse count", last_bits, 10);
    check("R10 sessions", sessions, 1);
    check("R10 rdata untouched", {16'd0, rdata}, 32'h8001);
    repeat (10) @(negedge clk);
    check("R10 stays idle", {31'd0, busy}, 32'd0);
    check("R11 clk idle low", {31'd0, ser_clk}, 32'd0);
    check("R1 sel idle low", {31'd0, ser_sel}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule